// File: doc/BRIEF.md
# SPI Slave Transceiver with Collision and Overflow Detection

This block is the slave end of an SPI link, running from the system clock. The three incoming pins are the serial clock, the serial data in and the active-low select. Each pin passes through a two-flop synchroniser, and clock edges are detected in the system domain. Received bits collect in a shift register. When a byte is complete it moves into a holding buffer, so a finished byte can wait for software while the next one arrives. The same shift register drives the serial data out, most significant bit first, in SPI mode 0: the master samples on the rising clock edge and the slave changes its output on the falling edge.

Software uses a small register interface. A write strobe loads a byte for transmission. A read strobe takes the received byte and releases the buffer. Two sticky error flags, one for a write collision and one for a receive overflow, each have their own clear input. A one-cycle interrupt pulse marks each byte stored in the buffer. An overwrite mode lets each new byte replace an unread one. In that mode every received byte is sent on during the following byte, so several slaves can be chained into one long shift register.

Top module: `spi_err_slave`

## Requirements
- R1: When the eighth bit of a selected transfer completes, the assembled byte is placed in the holding buffer (bit 7 is the first bit received), `bufFull` goes high, and `irqPulse` is high for exactly one clock.
- R2: A read strobe on `rdEn` clears `bufFull` on the next clock. `rdData` always shows the holding buffer.
- R3: A byte accepted through `wrEn` while no byte is in progress appears on `misoOut` during the next transfer, most significant bit first. The slave changes its output after each falling clock edge, so the master can sample on the rising edge. If no byte is written, the next transfer sends back the last byte received.
- R4: A write strobe while a byte is partly shifted sets `wcolFlag`, and the written data is discarded.
- R5: While `wcolFlag` is high, every write is ignored. The flag stays high until `wcolClr` is pulsed.
- R6: With overwrite mode off, a byte that completes while `bufFull` is high sets `ovfFlag`, no interrupt pulse is raised, and the buffer keeps the old byte. `ovfFlag` stays high until `ovfClr` is pulsed.
- R7: With `overwriteEn` high, every completed byte replaces the buffer contents even if unread, `ovfFlag` is never set, and the byte received is sent out during the following transfer.
- R8: Deasserting select (`ssNIn` high) returns the bit counter to zero. A partial byte never reaches the buffer, and the next transfer is aligned to the byte boundary.
- R9: Clock edges while `ssNIn` is high are ignored: no bits are shifted, `misoOut` does not change, and no byte completes.
- R10: After reset, `bufFull`, `wcolFlag`, `ovfFlag`, `irqPulse` and `misoOut` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least four times the SPI clock rate |
| rstN | input | 1 | Active-low synchronous reset |
| sckIn | input | 1 | SPI clock from the master (idles low) |
| ssNIn | input | 1 | Active-low slave select |
| mosiIn | input | 1 | Serial data from the master |
| misoOut | output | 1 | Serial data to the master |
| wrEn | input | 1 | Write strobe for a transmit byte |
| wrData | input | 8 | Transmit byte |
| rdEn | input | 1 | Read strobe, releases the holding buffer |
| rdData | output | 8 | Holding buffer contents |
| overwriteEn | input | 1 | Overwrite (daisy-chain) mode |
| wcolClr | input | 1 | Clears the write-collision flag |
| ovfClr | input | 1 | Clears the overflow flag |
| bufFull | output | 1 | Holding buffer holds an unread byte |
| wcolFlag | output | 1 | Sticky write-collision flag |
| ovfFlag | output | 1 | Sticky receive-overflow flag |
| irqPulse | output | 1 | One-cycle pulse per byte stored |

## Verification
The hardest case to set up is a write collision, because it needs a write that lands while the bit counter sits between one and seven. The bench gets there by lowering select and sending only three clock pulses, then writing. It then raises select partway through the byte. This shows in one sequence that the partial bits never reach the buffer and that a write made while the flag is set is lost. The proof is at the output: the next full transfer sends out the earlier accepted byte moved three places left, with the three partial bits filling the low end.

// File: rtl/spi_slv_pkg.sv
package spi_slv_pkg;
  // Strobes from control to datapath, valid for one system clock each.
  typedef struct packed {
    logic sample;   // capture serial input bit (rising SCK)
    logic shift;    // advance shift register (falling SCK)
    logic loadTx;   // load accepted write into shift register
    logic store;    // move assembled byte into holding buffer
  } spiStrobe_t;
endpackage

// File: rtl/spi_pin_sync.sv
module spi_pin_sync #(
  parameter int NUM_PINS = 3,
  parameter int STAGES = 2,
  parameter logic [NUM_PINS-1:0] RST_VAL = '0
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [NUM_PINS-1:0] pinsIn,
  output logic [NUM_PINS-1:0] pinsOut
);
  for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
    logic [STAGES-1:0] chain;
    always_ff @(posedge clk) begin
      if (!rstN) chain <= {STAGES{RST_VAL[p]}};
      else       chain <= {chain[STAGES-2:0], pinsIn[p]};
    end
    assign pinsOut[p] = chain[STAGES-1];
  end
endmodule

// File: rtl/spi_slv_ctrl.sv
module spi_slv_ctrl
  import spi_slv_pkg::*;
#(
  parameter int DATA_W = 8,
  localparam int CNT_W = $clog2(DATA_W + 1)
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       sckSync,
  input  logic       ssNSync,
  input  logic       wrEn,
  input  logic       rdEn,
  input  logic       overwriteEn,
  input  logic       wcolClr,
  input  logic       ovfClr,
  output spiStrobe_t strobe,
  output logic       bufFull,
  output logic       wcolFlag,
  output logic       ovfFlag,
  output logic       irqPulse
);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(DATA_W);

  logic             sckPrev;
  logic [CNT_W-1:0] bitCnt;
  logic             selected, sckRise, sckFall, byteDone;
  logic             busy, wrTry, setWcol, setOvf;

  always_comb begin
    selected = !ssNSync;
    sckRise  = selected && sckSync && !sckPrev;
    sckFall  = selected && !sckSync && sckPrev;
    byteDone = sckFall && (bitCnt == LAST);
    busy     = (bitCnt != '0);
    wrTry    = wrEn && !wcolFlag;
    setWcol  = wrTry && busy;
    setOvf   = byteDone && !overwriteEn && bufFull;

    strobe.sample   = sckRise;
    strobe.shift    = sckFall;
    strobe.loadTx   = wrTry && !busy;
    strobe.store    = byteDone && (overwriteEn || !bufFull);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      sckPrev  <= 1'b0;
      bitCnt   <= '0;
      bufFull  <= 1'b0;
      wcolFlag <= 1'b0;
      ovfFlag  <= 1'b0;
      irqPulse <= 1'b0;
    end else begin
      sckPrev <= sckSync;

      if (!selected || byteDone) bitCnt <= '0;
      else if (sckRise && bitCnt != LAST) bitCnt <= bitCnt + 1'b1;

      if (strobe.store) bufFull <= 1'b1;
      else if (rdEn)    bufFull <= 1'b0;

      irqPulse <= strobe.store;

      if (setWcol)      wcolFlag <= 1'b1;
      else if (wcolClr) wcolFlag <= 1'b0;

      if (setOvf)       ovfFlag <= 1'b1;
      else if (ovfClr)  ovfFlag <= 1'b0;
    end
  end
endmodule

// File: rtl/spi_slv_data.sv
module spi_slv_data
  import spi_slv_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              mosiSync,
  input  spiStrobe_t        strobe,
  input  logic [DATA_W-1:0] wrData,
  output logic              misoOut,
  output logic [DATA_W-1:0] rdData
);
  logic              rxBit;
  logic [DATA_W-1:0] shiftReg, holdBuf, nextShift;

  assign nextShift = {shiftReg[DATA_W-2:0], rxBit};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rxBit    <= 1'b0;
      shiftReg <= '0;
      holdBuf  <= '0;
    end else begin
      if (strobe.sample) rxBit <= mosiSync;

      if (strobe.loadTx)     shiftReg <= wrData;
      else if (strobe.shift) shiftReg <= nextShift;

      if (strobe.store) holdBuf <= nextShift;
    end
  end

  assign misoOut = shiftReg[DATA_W-1];
  assign rdData  = holdBuf;
endmodule

// File: rtl/spi_err_slave.sv
module spi_err_slave
  import spi_slv_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sckIn,
  input  logic              ssNIn,
  input  logic              mosiIn,
  output logic              misoOut,
  input  logic              wrEn,
  input  logic [DATA_W-1:0] wrData,
  input  logic              rdEn,
  output logic [DATA_W-1:0] rdData,
  input  logic              overwriteEn,
  input  logic              wcolClr,
  input  logic              ovfClr,
  output logic              bufFull,
  output logic              wcolFlag,
  output logic              ovfFlag,
  output logic              irqPulse
);
  logic [2:0] pinsSync;
  spiStrobe_t strobe;

  spi_pin_sync #(.NUM_PINS(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)) u_sync (
    .clk(clk), .rstN(rstN),
    .pinsIn({ssNIn, sckIn, mosiIn}),
    .pinsOut(pinsSync)
  );

  spi_slv_ctrl #(.DATA_W(DATA_W)) u_ctrl (
    .clk(clk), .rstN(rstN),
    .sckSync(pinsSync[1]), .ssNSync(pinsSync[2]),
    .wrEn(wrEn), .rdEn(rdEn), .overwriteEn(overwriteEn),
    .wcolClr(wcolClr), .ovfClr(ovfClr),
    .strobe(strobe), .bufFull(bufFull), .wcolFlag(wcolFlag),
    .ovfFlag(ovfFlag), .irqPulse(irqPulse)
  );

  spi_slv_data #(.DATA_W(DATA_W)) u_data (
    .clk(clk), .rstN(rstN),
    .mosiSync(pinsSync[0]), .strobe(strobe), .wrData(wrData),
    .misoOut(misoOut), .rdData(rdData)
  );
endmodule

// File: rtl/spi_err_slave_chk.sv
module spi_err_slave_chk (
  input logic clk,
  input logic rstN,
  input logic rdEn,
  input logic wcolClr,
  input logic ovfClr,
  input logic overwriteEn,
  input logic irqPulse,
  input logic bufFull,
  input logic wcolFlag,
  input logic ovfFlag
);
  a_r1_irq_one_cycle: assert property (@(posedge clk) disable iff (!rstN)
    irqPulse |=> !irqPulse);
  a_r1_irq_with_full: assert property (@(posedge clk) disable iff (!rstN)
    irqPulse |-> bufFull);
  a_r2_read_releases: assert property (@(posedge clk) disable iff (!rstN)
    rdEn |=> (!bufFull || irqPulse));
  a_r5_wcol_sticky: assert property (@(posedge clk) disable iff (!rstN)
    (wcolFlag && !wcolClr) |=> wcolFlag);
  a_r6_ovf_sticky: assert property (@(posedge clk) disable iff (!rstN)
    (ovfFlag && !ovfClr) |=> ovfFlag);
  a_r7_no_overflow: assert property (@(posedge clk) disable iff (!rstN)
    (overwriteEn && !ovfFlag) |=> !ovfFlag);
endmodule

bind spi_err_slave spi_err_slave_chk u_chk (
  .clk(clk), .rstN(rstN), .rdEn(rdEn), .wcolClr(wcolClr), .ovfClr(ovfClr),
  .overwriteEn(overwriteEn), .irqPulse(irqPulse), .bufFull(bufFull),
  .wcolFlag(wcolFlag), .ovfFlag(ovfFlag)
);

// File: tb/spi_err_slave_bench.sv
module spi_err_slave_bench;
  localparam int CLK_PERIOD = 10;
  localparam int HALF = 6;   // system clocks per SCK half period

  logic clk = 1'b0, rstN = 1'b0;
  logic sck = 1'b0, ssN = 1'b1, mosi = 1'b0, miso;
  logic wrEn = 1'b0, rdEn = 1'b0, ovr = 1'b0, wcolClr = 1'b0, ovfClr = 1'b0;
  logic [7:0] wrData = '0, rdData;
  logic bufFull, wcolFlag, ovfFlag, irqPulse;
  int checks = 0, errors = 0, irqCnt = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  spi_err_slave u_spi_err_slave (
    .clk(clk), .rstN(rstN), .sckIn(sck), .ssNIn(ssN), .mosiIn(mosi),
    .misoOut(miso), .wrEn(wrEn), .wrData(wrData), .rdEn(rdEn),
    .rdData(rdData), .overwriteEn(ovr), .wcolClr(wcolClr), .ovfClr(ovfClr),
    .bufFull(bufFull), .wcolFlag(wcolFlag), .ovfFlag(ovfFlag),
    .irqPulse(irqPulse)
  );

  always @(posedge clk) if (rstN && irqPulse) irqCnt <= irqCnt + 1;

  typedef struct packed {
    logic       wr;
    logic [7:0] tx;
    logic [7:0] mosiB;
    logic       rd;
    logic [7:0] expMiso;
    logic [7:0] expBuf;
    logic       expOvf;
    logic       expIrq;
  } vec_t;

  // overwrite off; entry 2 overflows and echoes the previous received byte
  localparam vec_t VEC [0:3] = '{
    '{1'b1, 8'hA5, 8'h3C, 1'b1, 8'hA5, 8'h3C, 1'b0, 1'b1},
    '{1'b1, 8'h0F, 8'hC3, 1'b0, 8'h0F, 8'hC3, 1'b0, 1'b1},
    '{1'b0, 8'h00, 8'h77, 1'b1, 8'hC3, 8'hC3, 1'b1, 1'b0},
    '{1'b1, 8'h81, 8'h18, 1'b1, 8'h81, 8'h18, 1'b1, 1'b1}
  };

  task automatic waitClk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic pulse(ref logic sig);
    @(negedge clk) sig = 1'b1;
    @(negedge clk) sig = 1'b0;
  endtask

  task automatic writeByte(input logic [7:0] d);
    @(negedge clk) begin wrEn = 1'b1; wrData = d; end
    @(negedge clk) wrEn = 1'b0;
  endtask

  task automatic xfer(input logic [7:0] b, output logic [7:0] got);
    ssN = 1'b0;
    waitClk(HALF);
    for (int i = 7; i >= 0; i--) begin
      mosi = b[i];
      waitClk(HALF);
      sck = 1'b1; got[i] = miso;
      waitClk(HALF);
      sck = 1'b0;
    end
    waitClk(HALF);
    ssN = 1'b1;
    waitClk(HALF);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] got;
    int irqBefore;
    waitClk(4);
    rstN = 1'b1;
    waitClk(3);
    // R10 reset state
    check("R10 bufFull", bufFull, 0);
    check("R10 wcolFlag", wcolFlag, 0);
    check("R10 ovfFlag", ovfFlag, 0);
    check("R10 misoOut", miso, 0);
    check("R10 irq", irqCnt, 0);

    // table-driven transfers, overwrite off
    for (int v = 0; v < 4; v++) begin
      if (VEC[v].wr) writeByte(VEC[v].tx);
      irqBefore = irqCnt;
      xfer(VEC[v].mosiB, got);
      check("R3 miso byte", got, VEC[v].expMiso);
      check("R1/R6 buffer", rdData, VEC[v].expBuf);
      check("R1 bufFull", bufFull, 1);
      check("R6 ovfFlag", ovfFlag, VEC[v].expOvf);
      check("R1 irq count", irqCnt - irqBefore, VEC[v].expIrq);
      if (VEC[v].rd) begin
        pulse(rdEn);
        check("R2 read clears full", bufFull, 0);
      end
    end

    // R6 overflow flag clear
    pulse(ovfClr);
    waitClk(1);
    check("R6 ovfClr", ovfFlag, 0);

    // R9 clock ignored while deselected (shift register holds 18, miso 0)
    irqBefore = irqCnt;
    mosi = 1'b1;
    for (int k = 0; k < 8; k++) begin
      waitClk(HALF); sck = 1'b1; waitClk(HALF); sck = 1'b0;
    end
    waitClk(HALF);
    check("R9 miso unchanged", miso, 0);
    check("R9 no byte", bufFull, 0);
    check("R9 no irq", irqCnt - irqBefore, 0);

    // R4/R5/R8 collision mid-byte, then abort by raising select
    writeByte(8'h5A);
    ssN = 1'b0;
    waitClk(HALF);
    for (int i = 0; i < 3; i++) begin
      mosi = (i != 1);
      waitClk(HALF); sck = 1'b1; waitClk(HALF); sck = 1'b0;
    end
    waitClk(HALF);
    writeByte(8'h11);
    check("R4 wcol set", wcolFlag, 1);
    ssN = 1'b1;
    waitClk(HALF);
    check("R8 partial byte dropped", bufFull, 0);
    writeByte(8'h22);
    check("R5 wcol still set", wcolFlag, 1);
    xfer(8'h96, got);
    check("R5 writes ignored", got, 8'hD5);
    check("R8 realigned byte", rdData, 8'h96);
    pulse(rdEn);
    pulse(wcolClr);
    waitClk(1);
    check("R5 wcolClr", wcolFlag, 0);
    writeByte(8'h33);
    xfer(8'h00, got);
    check("R5 write after clear", got, 8'h33);
    pulse(rdEn);

    // R7 overwrite mode chains bytes
    ovr = 1'b1;
    writeByte(8'h44);
    xfer(8'hAB, got);
    check("R7 first miso", got, 8'h44);
    irqBefore = irqCnt;
    xfer(8'hCD, got);
    check("R7 previous byte out", got, 8'hAB);
    check("R7 buffer replaced", rdData, 8'hCD);
    check("R7 no overflow", ovfFlag, 0);
    check("R7 irq on replace", irqCnt - irqBefore, 1);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule